// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Comparator

This block keeps the tags of a small direct-mapped cache and decides, for each access, whether the addressed line is present. The low address bits select one of 1024 lines. The upper address bits form a 15-bit tag, which is compared with the tag stored for that line. A match enables the cache data buffer. A mismatch on a lookup tells the controller to fetch from main memory.

The tag is held in two banks of about half its width. Each bank reports its own match, and the final hit is the AND of the two, so a difference in either half gives a miss. The upper bank also stores one extra bit per entry, which is always written as one and always compared against one. This bit acts as the line's valid flag.

Driving the active-low `flush_n` input low for one clock clears the valid flag of every line in that clock. After that, no line can hit until it has been written again. A write stores the presented tag at the addressed line and sets its valid flag.

Top module: `tag_cmp_top`

## Requirements
- R1: The tag is 15 bits (`addr_tag`) and the index is 10 bits (`line_idx`), giving 1024 independent lines. Both index 0 and index 1023 can store a tag and hit on it.
- R2: With `flush_n` high, a clock edge that has `wr_en` high stores `addr_tag` at `line_idx` and marks that line valid. A lookup of the same index and tag in the next cycle gives `buf_en`=1 and `mem_fetch`=0.
- R3: A lookup whose tag differs from the stored tag only in the lower half, bits 6:0, is a miss: `buf_en`=0 and `mem_fetch`=1.
- R4: A lookup whose tag differs from the stored tag only in the upper half, bits 14:7, is a miss.
- R5: A clock edge with `flush_n` low invalidates every line. Afterwards every index misses, for any tag including all zeros, until that index is written again.
- R6: While `flush_n` is low, `buf_en` and `mem_fetch` are both 0, and writes have no effect.
- R7: `buf_en` and `mem_fetch` are combinational. During a cycle in which a line is being written, a lookup of that line sees the contents it held before the write.
- R8: With `lookup` low, `buf_en` and `mem_fetch` are both 0.
- R9: With `lookup` high and `flush_n` high, exactly one of `buf_en` and `mem_fetch` is 1.
- R10: Writing one index leaves the hit or miss result of every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and invalidation take effect on its rising edge |
| flush_n | input | 1 | Synchronous active-low invalidate of all lines |
| lookup | input | 1 | A read access is being presented this cycle |
| wr_en | input | 1 | Store `addr_tag` at `line_idx` on this edge |
| line_idx | input | 10 | Line index taken from the low address bits |
| addr_tag | input | 15 | Tag taken from the upper address bits |
| buf_en | output | 1 | Hit: enables the cache data buffer |
| mem_fetch | output | 1 | Miss on a lookup: request a main-memory access |

## Verification
The hardest situation to reach is a lookup whose stored data matches bit for bit while the entry is invalid. That happens when a line was written, then flushed, and is then probed with exactly the tag it held. The bench writes known tags, flushes, and probes those same tags, including the all-zero tag at index 0. It also writes a line while the flush is held and checks that the line still misses afterwards. A separate cycle drives a write and a lookup of the same line together, to show that the lookup sees the old tag before the new one becomes visible.

// File: rtl/tag_cmp_pkg.sv
package tag_cmp_pkg;
    localparam int IDX_W  = 10;
    localparam int TAG_W  = 15;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int LO_W   = TAG_W / 2;
    localparam int HI_W   = TAG_W - LO_W;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } tag_split_t;

    function automatic tag_split_t split_tag(input tag_t t);
        tag_split_t s;
        s.hi = t[TAG_W-1:LO_W];
        s.lo = t[LO_W-1:0];
        return s;
    endfunction
endpackage

// File: rtl/tag_bank.sv
module tag_bank #(
    parameter int W        = 8,
    parameter int IDX_W    = 10,
    parameter bit USE_FLAG = 1'b1
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     cdata,
    output logic             match
);
    localparam int DEPTH = 1 << IDX_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    generate
        if (USE_FLAG) begin : g_flag
            logic [DEPTH-1:0] flag;
            always_ff @(posedge clk) begin
                if (clear) begin
                    flag <= '0;
                end else if (we) begin
                    flag[idx] <= 1'b1;
                end
            end
            always_comb begin
                match = ({flag[idx], mem[idx]} == {1'b1, cdata});
            end
        end else begin : g_plain
            always_comb begin
                match = (mem[idx] == cdata);
            end
        end
    endgenerate
endmodule

// File: rtl/hit_gate.sv
module hit_gate (
    input  logic flush_n,
    input  logic lookup,
    input  logic m_lo,
    input  logic m_hi,
    output logic buf_en,
    output logic mem_fetch
);
    logic both;
    always_comb begin
        both      = m_lo & m_hi;
        buf_en    = flush_n & lookup & both;
        mem_fetch = flush_n & lookup & ~both;
    end
endmodule

// File: rtl/tag_cmp_top.sv
module tag_cmp_top
    import tag_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             flush_n,
    input  logic             lookup,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] line_idx,
    input  logic [TAG_W-1:0] addr_tag,
    output logic             buf_en,
    output logic             mem_fetch
);
    tag_split_t parts;
    logic       we_ok;
    logic       clr;
    logic       m_lo;
    logic       m_hi;

    always_comb begin
        parts = split_tag(addr_tag);
        we_ok = wr_en & flush_n;
        clr   = ~flush_n;
    end

    tag_bank #(.W(LO_W), .IDX_W(IDX_W), .USE_FLAG(1'b0)) u_bank_lo (
        .clk   (clk),
        .clear (clr),
        .we    (we_ok),
        .idx   (line_idx),
        .wdata (parts.lo),
        .cdata (parts.lo),
        .match (m_lo)
    );

    tag_bank #(.W(HI_W), .IDX_W(IDX_W), .USE_FLAG(1'b1)) u_bank_hi (
        .clk   (clk),
        .clear (clr),
        .we    (we_ok),
        .idx   (line_idx),
        .wdata (parts.hi),
        .cdata (parts.hi),
        .match (m_hi)
    );

    hit_gate u_gate (
        .flush_n   (flush_n),
        .lookup    (lookup),
        .m_lo      (m_lo),
        .m_hi      (m_hi),
        .buf_en    (buf_en),
        .mem_fetch (mem_fetch)
    );
endmodule

// File: rtl/tag_cmp_chk.sv
module tag_cmp_chk
    import tag_cmp_pkg::*;
(
    input logic             clk,
    input logic             flush_n,
    input logic             lookup,
    input logic             wr_en,
    input logic [IDX_W-1:0] line_idx,
    input logic [TAG_W-1:0] addr_tag,
    input logic             buf_en,
    input logic             mem_fetch
);
    logic seen;
    always_ff @(posedge clk) seen <= 1'b1;

    AST_FLUSH_QUIET: assert property (@(posedge clk)
        seen && !flush_n |-> !buf_en && !mem_fetch); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!flush_n || !seen)
        !lookup |-> !buf_en && !mem_fetch); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!flush_n || !seen)
        lookup |-> (buf_en ^ mem_fetch)); // R9

    AST_POST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!flush_n || !seen)
        ($past(!flush_n) && lookup) |-> !buf_en); // R5

    AST_WRITE_THEN_HIT: assert property (@(posedge clk) disable iff (!flush_n || !seen)
        ($past(wr_en && flush_n) && lookup && line_idx == $past(line_idx)
         && addr_tag == $past(addr_tag)) |-> buf_en); // R2
endmodule

bind tag_cmp_top tag_cmp_chk u_chk (.*);

// File: tb/tag_cmp_top_tb.sv
module tag_cmp_top_tb;
    logic        clk = 1'b0;
    logic        flush_n = 1'b0;
    logic        lookup = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  line_idx = '0;
    logic [14:0] addr_tag = '0;
    logic        buf_en;
    logic        mem_fetch;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    tag_cmp_top u_dut (
        .clk       (clk),
        .flush_n   (flush_n),
        .lookup    (lookup),
        .wr_en     (wr_en),
        .line_idx  (line_idx),
        .addr_tag  (addr_tag),
        .buf_en    (buf_en),
        .mem_fetch (mem_fetch)
    );

    // entry: [26] write, [25:16] index, [15:1] tag, [0] expected hit
    localparam int NV = 12;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 10'd5,    15'h2A5C, 1'b0},
        {1'b0, 10'd5,    15'h2A5C, 1'b1},   // R2
        {1'b0, 10'd5,    15'h2A5D, 1'b0},   // R3 low bit 0
        {1'b0, 10'd5,    15'h2A1C, 1'b0},   // R3 low bit 6
        {1'b0, 10'd5,    15'h6A5C, 1'b0},   // R4 bit 14
        {1'b0, 10'd5,    15'h2ADC, 1'b0},   // R4 bit 7
        {1'b0, 10'd6,    15'h2A5C, 1'b0},   // R10
        {1'b1, 10'd1023, 15'h7FFF, 1'b0},
        {1'b0, 10'd1023, 15'h7FFF, 1'b1},   // R1
        {1'b1, 10'd0,    15'h0000, 1'b0},
        {1'b0, 10'd0,    15'h0000, 1'b1},   // R1
        {1'b0, 10'd5,    15'h2A5C, 1'b1}    // R10
    };
    localparam int VREQ [NV] = '{2, 2, 3, 3, 4, 4, 10, 1, 1, 1, 1, 10};

    task automatic check(input string req, input logic act_b, input logic act_m,
                         input logic exp_b, input logic exp_m);
        checks++;
        if (act_b !== exp_b || act_m !== exp_m) begin
            errors++;
            $display("FAIL %s: buf_en=%b mem_fetch=%b expected buf_en=%b mem_fetch=%b",
                     req, act_b, act_m, exp_b, exp_m);
        end
    endtask

    task automatic do_write(input logic [9:0] i, input logic [14:0] t);
        @(negedge clk);
        wr_en = 1'b1; lookup = 1'b0; line_idx = i; addr_tag = t;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_look(input logic [9:0] i, input logic [14:0] t,
                           input logic exp, input string req);
        @(negedge clk);
        wr_en = 1'b0; lookup = 1'b1; line_idx = i; addr_tag = t;
        #1;
        check(req, buf_en, mem_fetch, exp, ~exp);
        @(negedge clk);
        lookup = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // reset: flush held low
        repeat (3) @(negedge clk);
        lookup = 1'b1; #1;
        check("R6 reset quiet", buf_en, mem_fetch, 1'b0, 1'b0);
        @(negedge clk);
        flush_n = 1'b1; lookup = 1'b0;
        do_look(10'd0, 15'h0000, 1'b0, "R5 reset state zero tag");

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][26]) begin
                do_write(VEC[k][25:16], VEC[k][15:1]);
            end else begin
                do_look(VEC[k][25:16], VEC[k][15:1], VEC[k][0],
                        $sformatf("R%0d vector %0d", VREQ[k], k));
            end
        end

        // R8: lookup low gives no outputs, even on a stored line
        @(negedge clk);
        lookup = 1'b0; line_idx = 10'd5; addr_tag = 15'h2A5C; #1;
        check("R8 idle", buf_en, mem_fetch, 1'b0, 1'b0);

        // R7: write and lookup same line in one cycle sees old tag
        @(negedge clk);
        wr_en = 1'b1; lookup = 1'b1; line_idx = 10'd5; addr_tag = 15'h1111; #1;
        check("R7 new tag not yet visible", buf_en, mem_fetch, 1'b0, 1'b1);
        @(negedge clk);
        wr_en = 1'b0; lookup = 1'b0;
        do_look(10'd5, 15'h1111, 1'b1, "R7 new tag after edge");
        do_look(10'd5, 15'h2A5C, 1'b0, "R7 old tag replaced");
        @(negedge clk);
        wr_en = 1'b1; lookup = 1'b1; line_idx = 10'd5; addr_tag = 15'h3333;
        #1; addr_tag = 15'h1111; #1;
        check("R7 old contents during write", buf_en, mem_fetch, 1'b1, 1'b0);
        @(negedge clk);
        wr_en = 1'b0; lookup = 1'b0;

        // R6: flush with a write in progress; outputs quiet, write ignored
        @(negedge clk);
        flush_n = 1'b0; wr_en = 1'b1; lookup = 1'b1;
        line_idx = 10'd9; addr_tag = 15'h0ABC; #1;
        check("R6 quiet during flush", buf_en, mem_fetch, 1'b0, 1'b0);
        @(negedge clk);
        flush_n = 1'b1; wr_en = 1'b0; lookup = 1'b0;
        do_look(10'd9, 15'h0ABC, 1'b0, "R6 write during flush ignored");

        // R5: every previously stored line misses
        do_look(10'd5, 15'h1111, 1'b0, "R5 flushed line 5");
        do_look(10'd1023, 15'h7FFF, 1'b0, "R5 flushed line 1023");
        do_look(10'd0, 15'h0000, 1'b0, "R5 flushed line 0 zero tag");
        do_write(10'd0, 15'h0000);
        do_look(10'd0, 15'h0000, 1'b1, "R5 rewritten line hits");
        do_look(10'd1023, 15'h7FFF, 1'b0, "R10 other line still invalid");

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule